// File: doc/BRIEF.md
# Multi-Level DMA Address Page Walker

This block turns a DMA address issued by a device into a physical address. The device is named by a 16-bit requester ID. The upper byte selects a root entry, and the lower byte selects a context entry in the table that the root entry points at. The context entry gives the root of a multi-level page table and a width code that sets the walk depth.

The walker reads every table entry through a 64-bit memory read port with a request/valid handshake. It accepts one translation at a time. While it walks, it ANDs together the read and write permissions of each entry. It stops early when an entry marks a large page. The result is a single-cycle response that carries:
- the translated address,
- the bytes left in the mapped region,
- the final permissions,
- a fault flag.

When translation is switched off, addresses pass straight through. If no root table has been installed, every request faults.

Top module: `dma_xlate_walker`

## Requirements
- R1: When `cfg_xlate_en` is low, an accepted request produces a response in the next cycle. The response has `rsp_addr` equal to `req_addr`, `rsp_perm` = 2'b11 (bit 1 write, bit 0 read), `rsp_fault` = 0 and `rsp_size` = 4096 minus `req_addr[11:0]`. No memory read is issued.
- R2: When `cfg_xlate_en` is high and `cfg_root_set` is low, an accepted request responds in the next cycle with `rsp_fault` = 1, `rsp_perm` = 0, `rsp_addr` = 0 and `rsp_size` = 0. No memory read is issued.
- R3: The requester ID is split into a bus number (bits 15:8) and a device/function number (bits 7:0). The walker reads memory in this order:
  - the root entry at `cfg_root_base` + bus×16;
  - the context low word at (root bits 63:12 shifted left by 12) + devfn×16;
  - the context high word at the context low-word address + 8.
- R4: Bit 0 is the present bit in both the root entry and the context low word. If that bit is clear, the walk ends with a fault, perm 0, address 0 and size 0.
- R5: The width code is context bits 66:64, which are high-word bits 2:0. The walk depth is code+2 levels.
  - A code above 3 faults, with perm 0, and no page-table read is made.
  - Levels are numbered k = depth−1 down to 0.
  - The entry for level k is read at the table base + `req_addr[12+9k +: 9]`×8.
  - The first table base is context bits 63:12 shifted left by 12. Each later base is the previous entry's bits 63:12 shifted left by 12.
- R6: In a page-table entry, bit 0 grants read and bit 1 grants write. The reported permission is the AND of these bits over all entries read.
- R7: An entry whose bits 1:0 are both zero ends the walk with a fault, perm 0, address 0 and size 0.
- R8: Bit 7 set in an entry at level k>0 ends the walk at that level.
  - The address is the entry's bits 63:12 shifted left by 12, with bits (12+9k−1):0 replaced by the same bits of `req_addr`.
  - The size is 2^(12+9k) minus that offset.
  - At level 0, bit 7 is ignored.
- R9: A walk that reaches level 0 gives an address of {leaf bits 63:12, `req_addr[11:0]`} and a size of 4096 minus `req_addr[11:0]`.
- R10: `rsp_fault` is 1 when the requested access is missing from the final permissions. A write request needs perm bit 1 and a read request needs perm bit 0. Address and size are still reported in this case.
- R11: The handshakes behave as follows:
  - `req_ready` is low from acceptance until the response.
  - `rsp_valid` is a one-cycle pulse.
  - `mem_rd_addr` holds steady while `mem_rd_req` waits for `mem_rd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xlate_en | input | 1 | Translation enabled status |
| cfg_root_set | input | 1 | Root table installed status |
| cfg_root_base | input | 64 | Root table base address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_sid | input | 16 | Requester ID (bus, device/function) |
| req_addr | input | 64 | DMA address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_req | output | 1 | Table read request, held until data |
| mem_rd_addr | output | 64 | Table read address |
| mem_rd_vld | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data word |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 64 | Translated address |
| rsp_size | output | 64 | Bytes left in the mapped region |
| rsp_perm | output | 2 | Final permissions, bit 1 write, bit 0 read |
| rsp_fault | output | 1 | Translation or permission failure |

## Verification
The assertions assume that memory raises `mem_rd_vld` only while `mem_rd_req` is high. They also assume that `mem_rd_vld` lasts one cycle per read, and that the configuration inputs do not change during a walk. The bench memory model meets these assumptions. It answers only a pending request, after a chosen latency of 0 to 3 cycles, and drops valid on the next falling edge. The bench changes configuration only while the walker is idle, and it sends a new request only after the previous response has been seen.

// File: rtl/xw_pkg.sv
// Package: shared state encoding and table-entry field positions for the
// DMA address page walker. Assumes 64-bit entries and 4 KB table alignment.
package xw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOT,
        ST_CTX_LO,
        ST_CTX_HI,
        ST_PTE,
        ST_RESP
    } walk_state_e;

    localparam int PERM_RD       = 0;   // entry bit granting read
    localparam int PERM_WR       = 1;   // entry bit granting write
    localparam int PRESENT_BIT   = 0;   // root / context present bit
    localparam int LARGE_BIT     = 7;   // large-page stop bit
    localparam int PTR_LSB       = 12;  // pointer field low bit
    localparam int ENTRY_SHIFT   = 3;   // log2 of page-table entry bytes
    localparam int SLOT_SHIFT    = 4;   // log2 of root/context entry bytes
    localparam int CODE_W        = 3;   // width code field width

    // Extract the 4 KB aligned table pointer held in an entry.
    function automatic logic [63:0] ptr_of(input logic [63:0] ent);
        return {ent[63:PTR_LSB], {PTR_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/xw_level_math.sv
// Level arithmetic: for walk level k, gives the region mask covering
// PAGE_SHIFT+LVL_BITS*k low address bits and the address of the entry
// that va selects within the table at tbl_base. Assumes lvl < MAX_LEVELS.
module xw_level_math
    import xw_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int LVL_BITS   = 9,
    parameter int MAX_LEVELS = 5,
    parameter int LVL_W      = 3
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [63:0]      tbl_base,
    input  logic [63:0]      va,
    output logic [63:0]      ent_addr,
    output logic [63:0]      reg_mask
);
    localparam logic [63:0] IDX_MASK = (64'd1 << LVL_BITS) - 64'd1;

    logic [63:0] mask_tab [MAX_LEVELS];
    logic [63:0] idx_tab  [MAX_LEVELS];
    logic [63:0] idx_sel;

    // One mask and index extractor per level.
    for (genvar g = 0; g < MAX_LEVELS; g++) begin : g_lvl
        assign mask_tab[g] = (64'd1 << (PAGE_SHIFT + LVL_BITS * g)) - 64'd1;
        assign idx_tab[g]  = (va >> (PAGE_SHIFT + LVL_BITS * g)) & IDX_MASK;
    end

    // Select the mask and index for the current level.
    always_comb begin
        reg_mask = '0;
        idx_sel  = '0;
        for (int i = 0; i < MAX_LEVELS; i++) begin
            if (lvl == LVL_W'(i)) begin
                reg_mask = mask_tab[i];
                idx_sel  = idx_tab[i];
            end
        end
    end

    assign ent_addr = tbl_base + (idx_sel << ENTRY_SHIFT);

endmodule

// File: rtl/xw_perm_merge.sv
// Permission merge: ANDs an entry's read/write bits into the running
// permissions, flags an entry with neither bit, and says whether the
// requested access survives. Purely combinational.
module xw_perm_merge
    import xw_pkg::*;
(
    input  logic [1:0] perm_in,
    input  logic [1:0] ent_rw,
    input  logic       want_write,
    output logic [1:0] perm_out,
    output logic       ent_empty,
    output logic       granted
);
    // Merge and grant decision.
    always_comb begin
        perm_out  = perm_in & ent_rw;
        ent_empty = (ent_rw == 2'b00);
        granted   = want_write ? perm_out[PERM_WR] : perm_out[PERM_RD];
    end

endmodule

// File: rtl/xw_result_compose.sv
// Result composition: joins the entry's page frame above the region mask
// with the request offset below it, and computes the bytes left in the
// region. Assumes reg_mask is of the form 2^n-1.
module xw_result_compose
    import xw_pkg::*;
(
    input  logic [63:0] ent,
    input  logic [63:0] va,
    input  logic [63:0] reg_mask,
    output logic [63:0] out_addr,
    output logic [63:0] out_size
);
    logic [63:0] offs;

    // Frame plus offset, and region remainder.
    always_comb begin
        offs     = va & reg_mask;
        out_addr = (ptr_of(ent) & ~reg_mask) | offs;
        out_size = (reg_mask + 64'd1) - offs;
    end

endmodule

// File: rtl/dma_xlate_walker.sv
// DMA address page walker top. Takes one request at a time and walks
// root entry, context entry (two words) and then code+2 page-table levels
// through a held-request memory read port. It emits a one-cycle response.
// Assumes mem_rd_vld is raised only while mem_rd_req is high, for one
// cycle per read, and that the cfg_* inputs are steady during a walk.
module dma_xlate_walker
    import xw_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int LVL_BITS   = 9,
    parameter int MAX_LEVELS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_xlate_en,
    input  logic        cfg_root_set,
    input  logic [63:0] cfg_root_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_sid,
    input  logic [63:0] req_addr,
    input  logic        req_write,
    output logic        mem_rd_req,
    output logic [63:0] mem_rd_addr,
    input  logic        mem_rd_vld,
    input  logic [63:0] mem_rd_data,
    output logic        rsp_valid,
    output logic [63:0] rsp_addr,
    output logic [63:0] rsp_size,
    output logic [1:0]  rsp_perm,
    output logic        rsp_fault
);
    localparam int              LVL_W     = $clog2(MAX_LEVELS);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_LEVELS - 2);
    localparam logic [63:0]     PAGE_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

    walk_state_e      state_q;
    logic [63:0]      va_q;
    logic             wr_q;
    logic [7:0]       devfn_q;
    logic [63:0]      rd_addr_q;
    logic [63:0]      ctx_ptr_q;
    logic [63:0]      base_q;
    logic [LVL_W-1:0] lvl_q;
    logic [1:0]       perm_q;
    logic [63:0]      rsp_addr_q;
    logic [63:0]      rsp_size_q;
    logic [1:0]       rsp_perm_q;
    logic             rsp_fault_q;

    logic [63:0]      ent_addr;
    logic [63:0]      reg_mask;
    logic [1:0]       perm_new;
    logic             ent_empty;
    logic             granted;
    logic [63:0]      cmp_addr;
    logic [63:0]      cmp_size;
    logic [CODE_W-1:0] width_code;
    logic             unused_rd_bits;

    assign width_code     = mem_rd_data[CODE_W-1:0];
    assign unused_rd_bits = ^{mem_rd_data[11:8], mem_rd_data[6:3]};

    xw_level_math #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .LVL_BITS   (LVL_BITS),
        .MAX_LEVELS (MAX_LEVELS),
        .LVL_W      (LVL_W)
    ) u_lvl (
        .lvl      (lvl_q),
        .tbl_base (base_q),
        .va       (va_q),
        .ent_addr (ent_addr),
        .reg_mask (reg_mask)
    );

    xw_perm_merge u_perm (
        .perm_in    (perm_q),
        .ent_rw     ({mem_rd_data[PERM_WR], mem_rd_data[PERM_RD]}),
        .want_write (wr_q),
        .perm_out   (perm_new),
        .ent_empty  (ent_empty),
        .granted    (granted)
    );

    xw_result_compose u_cmp (
        .ent      (mem_rd_data),
        .va       (va_q),
        .reg_mask (reg_mask),
        .out_addr (cmp_addr),
        .out_size (cmp_size)
    );

    // Walk state machine and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            devfn_q     <= '0;
            rd_addr_q   <= '0;
            ctx_ptr_q   <= '0;
            base_q      <= '0;
            lvl_q       <= '0;
            perm_q      <= '0;
            rsp_addr_q  <= '0;
            rsp_size_q  <= '0;
            rsp_perm_q  <= '0;
            rsp_fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_addr;
                        wr_q    <= req_write;
                        devfn_q <= req_sid[7:0];
                        if (!cfg_xlate_en) begin
                            rsp_addr_q  <= req_addr;
                            rsp_size_q  <= (PAGE_MASK + 64'd1) - (req_addr & PAGE_MASK);
                            rsp_perm_q  <= 2'b11;
                            rsp_fault_q <= 1'b0;
                            state_q     <= ST_RESP;
                        end else if (!cfg_root_set) begin
                            rsp_addr_q  <= '0;
                            rsp_size_q  <= '0;
                            rsp_perm_q  <= 2'b00;
                            rsp_fault_q <= 1'b1;
                            state_q     <= ST_RESP;
                        end else begin
                            rd_addr_q <= cfg_root_base + (64'(req_sid[15:8]) << SLOT_SHIFT);
                            state_q   <= ST_ROOT;
                        end
                    end
                end
                ST_ROOT: begin
                    if (mem_rd_vld) begin
                        if (!mem_rd_data[PRESENT_BIT]) begin
                            rsp_addr_q  <= '0;
                            rsp_size_q  <= '0;
                            rsp_perm_q  <= 2'b00;
                            rsp_fault_q <= 1'b1;
                            state_q     <= ST_RESP;
                        end else begin
                            rd_addr_q <= ptr_of(mem_rd_data) + (64'(devfn_q) << SLOT_SHIFT);
                            state_q   <= ST_CTX_LO;
                        end
                    end
                end
                ST_CTX_LO: begin
                    if (mem_rd_vld) begin
                        if (!mem_rd_data[PRESENT_BIT]) begin
                            rsp_addr_q  <= '0;
                            rsp_size_q  <= '0;
                            rsp_perm_q  <= 2'b00;
                            rsp_fault_q <= 1'b1;
                            state_q     <= ST_RESP;
                        end else begin
                            ctx_ptr_q <= ptr_of(mem_rd_data);
                            rd_addr_q <= rd_addr_q + 64'd8;
                            state_q   <= ST_CTX_HI;
                        end
                    end
                end
                ST_CTX_HI: begin
                    if (mem_rd_vld) begin
                        if (width_code > MAX_CODE) begin
                            rsp_addr_q  <= '0;
                            rsp_size_q  <= '0;
                            rsp_perm_q  <= 2'b00;
                            rsp_fault_q <= 1'b1;
                            state_q     <= ST_RESP;
                        end else begin
                            lvl_q   <= LVL_W'(width_code + CODE_W'(1));
                            base_q  <= ctx_ptr_q;
                            perm_q  <= 2'b11;
                            state_q <= ST_PTE;
                        end
                    end
                end
                ST_PTE: begin
                    if (mem_rd_vld) begin
                        if (ent_empty) begin
                            rsp_addr_q  <= '0;
                            rsp_size_q  <= '0;
                            rsp_perm_q  <= 2'b00;
                            rsp_fault_q <= 1'b1;
                            state_q     <= ST_RESP;
                        end else if (lvl_q == '0 || mem_rd_data[LARGE_BIT]) begin
                            rsp_addr_q  <= cmp_addr;
                            rsp_size_q  <= cmp_size;
                            rsp_perm_q  <= perm_new;
                            rsp_fault_q <= !granted;
                            state_q     <= ST_RESP;
                        end else begin
                            base_q <= ptr_of(mem_rd_data);
                            lvl_q  <= lvl_q - 1'b1;
                            perm_q <= perm_new;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port-side decodes of the walk state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_RESP);
        mem_rd_req  = (state_q == ST_ROOT) || (state_q == ST_CTX_LO) ||
                      (state_q == ST_CTX_HI) || (state_q == ST_PTE);
        mem_rd_addr = (state_q == ST_PTE) ? ent_addr : rd_addr_q;
    end

    assign rsp_addr  = rsp_addr_q;
    assign rsp_size  = rsp_size_q;
    assign rsp_perm  = rsp_perm_q;
    assign rsp_fault = rsp_fault_q;

    // R1: pass-through answers next cycle with the input address and full access.
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !cfg_xlate_en) |=>
            (rsp_valid && rsp_addr == $past(req_addr) && rsp_perm == 2'b11 && !rsp_fault));

    // R2: no root table installed means an immediate fault.
    a_r2_no_root: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && cfg_xlate_en && !cfg_root_set) |=>
            (rsp_valid && rsp_fault && rsp_perm == 2'b00));

    // R7: an entry with neither access bit faults with zero permissions.
    a_r7_empty_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTE && mem_rd_vld && ent_empty) |=>
            (rsp_valid && rsp_fault && rsp_perm == 2'b00));

    // R10: a clean response always carries the requested access.
    a_r10_grant_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (wr_q ? rsp_perm[PERM_WR] : rsp_perm[PERM_RD]));

    // R11: response is a single-cycle pulse, followed by readiness.
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11: a pending read keeps its request and address steady.
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_vld) |=> (mem_rd_req && $stable(mem_rd_addr)));

endmodule

// File: tb/tb_dma_xlate_walker.sv
// Directed bench for the DMA address page walker: a sparse memory model
// answers table reads with a chosen latency, and each task checks its own case.
module tb_dma_xlate_walker;

    localparam logic [63:0] ROOT_BASE = 64'h1_0000;
    localparam logic [63:0] CTX_TBL   = 64'h2_0000;
    localparam logic [63:0] PT_L0     = 64'h3_0000;
    localparam logic [63:0] PT_L1     = 64'h4_0000;
    localparam logic [63:0] PT_L2     = 64'h5_0000;
    localparam logic [63:0] PT_L3     = 64'h6_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xlate_en = 1'b0;
    logic        cfg_root_set = 1'b0;
    logic [63:0] cfg_root_base = ROOT_BASE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sid = '0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_req;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_vld = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [63:0] rsp_size;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int mem_lat = 0;
    int wait_cnt = 0;
    int nreads = 0;
    logic [63:0] rlog [16];
    logic [63:0] mem [logic [63:0]];

    logic [63:0] g_addr, g_size;
    logic [1:0]  g_perm;
    logic        g_fault;

    dma_xlate_walker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_xlate_en(cfg_xlate_en), .cfg_root_set(cfg_root_set),
        .cfg_root_base(cfg_root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_sid(req_sid),
        .req_addr(req_addr), .req_write(req_write),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_size(rsp_size),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles exp below 100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // Memory model: answers a pending read after mem_lat cycles, one-cycle valid.
    always @(negedge clk) begin
        if (mem_rd_vld) begin
            mem_rd_vld = 1'b0;
            wait_cnt = 0;
        end else if (mem_rd_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_rd_data = mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'd0;
                if (nreads < 16) rlog[nreads] = mem_rd_addr;
                nreads++;
                mem_rd_vld = 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] idx_of(input logic [63:0] va, input int k);
        return (va >> (12 + 9 * k)) & 64'h1FF;
    endfunction

    // Root entry and two-word context entry for a requester.
    task automatic set_ctx(input logic [15:0] sid, input logic [63:0] pt_root,
                           input logic [2:0] code, input bit root_p, input bit ctx_p);
        mem[ROOT_BASE + 64'(sid[15:8]) * 16] = CTX_TBL | 64'(root_p);
        mem[CTX_TBL + 64'(sid[7:0]) * 16]     = pt_root | 64'(ctx_p);
        mem[CTX_TBL + 64'(sid[7:0]) * 16 + 8] = 64'(code);
    endtask

    task automatic put_pte(input logic [63:0] base, input logic [63:0] va,
                           input int k, input logic [63:0] val);
        mem[base + idx_of(va, k) * 8] = val;
    endtask

    // Issue one request, check readiness drop and response pulse (R11).
    task automatic do_req(input logic [15:0] sid, input logic [63:0] va, input bit wr);
        int t;
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1; req_sid = sid; req_addr = va; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 ready low after accept", 64'(req_ready), 64'd0);
        t = 0;
        while (!rsp_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk("R11 response arrives", 64'(rsp_valid), 64'd1);
        g_addr = rsp_addr; g_size = rsp_size; g_perm = rsp_perm; g_fault = rsp_fault;
        @(negedge clk);
        chk("R11 response one cycle", 64'(rsp_valid), 64'd0);
        chk("R11 ready after response", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset;
        chk("R11 reset ready", 64'(req_ready), 64'd1);
        chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11 reset mem_rd_req", 64'(mem_rd_req), 64'd0);
    endtask

    task automatic t_pass_through;
        cfg_xlate_en = 1'b0; cfg_root_set = 1'b1;
        do_req(16'h0102, 64'h0000_1234_5678_9ABC, 1'b1);
        chk("R1 addr", g_addr, 64'h0000_1234_5678_9ABC);
        chk("R1 perm", 64'(g_perm), 64'd3);
        chk("R1 fault", 64'(g_fault), 64'd0);
        chk("R1 size", g_size, 64'h544);
        chk("R1 no reads", 64'(nreads), 64'd0);
    endtask

    task automatic t_no_root;
        cfg_xlate_en = 1'b1; cfg_root_set = 1'b0;
        do_req(16'h0102, 64'h5000, 1'b0);
        chk("R2 fault", 64'(g_fault), 64'd1);
        chk("R2 perm", 64'(g_perm), 64'd0);
        chk("R2 addr", g_addr, 64'd0);
        chk("R2 no reads", 64'(nreads), 64'd0);
        cfg_root_set = 1'b1;
    endtask

    task automatic t_full_walk;
        logic [63:0] va = 64'h0000_8765_4321_0ABC;
        mem.delete(); mem_lat = 2;
        set_ctx(16'h0305, PT_L0, 3'd2, 1'b1, 1'b1);
        put_pte(PT_L0, va, 3, PT_L1 | 64'h3);
        put_pte(PT_L1, va, 2, PT_L2 | 64'h3);
        put_pte(PT_L2, va, 1, PT_L3 | 64'h3);
        put_pte(PT_L3, va, 0, 64'hABCD_E003);
        do_req(16'h0305, va, 1'b1);
        chk("R3 root read addr", rlog[0], ROOT_BASE + 64'h30);
        chk("R3 ctx low addr", rlog[1], CTX_TBL + 64'h50);
        chk("R3 ctx high addr", rlog[2], CTX_TBL + 64'h58);
        chk("R5 first level addr", rlog[3], PT_L0 + idx_of(va, 3) * 8);
        chk("R5 last level addr", rlog[6], PT_L3 + idx_of(va, 0) * 8);
        chk("R5 read count 4 levels", 64'(nreads), 64'd7);
        chk("R9 addr", g_addr, 64'hABCD_EABC);
        chk("R9 size", g_size, 64'h544);
        chk("R6 perm", 64'(g_perm), 64'd3);
        chk("R10 fault", 64'(g_fault), 64'd0);
    endtask

    task automatic t_perm_mix;
        logic [63:0] va = 64'h0000_0040_1234_5678;
        mem.delete(); mem_lat = 0;
        set_ctx(16'h1122, PT_L0, 3'd1, 1'b1, 1'b1);
        put_pte(PT_L0, va, 2, PT_L1 | 64'h1);
        put_pte(PT_L1, va, 1, PT_L2 | 64'h3);
        put_pte(PT_L2, va, 0, 64'h9000_0003);
        do_req(16'h1122, va, 1'b1);
        chk("R6 read-only level masks write", 64'(g_perm), 64'd1);
        chk("R10 write faults", 64'(g_fault), 64'd1);
        chk("R10 addr still given", g_addr, 64'h9000_0678);
        do_req(16'h1122, va, 1'b0);
        chk("R10 read allowed", 64'(g_fault), 64'd0);
        chk("R5 read count 3 levels", 64'(nreads), 64'd6);
    endtask

    task automatic t_large_page;
        logic [63:0] va = 64'h0000_0012_3456_789A;
        mem.delete(); mem_lat = 1;
        set_ctx(16'h0001, PT_L0, 3'd1, 1'b1, 1'b1);
        put_pte(PT_L0, va, 2, PT_L1 | 64'h3);
        put_pte(PT_L1, va, 1, 64'h8_0021_5083);
        do_req(16'h0001, va, 1'b0);
        chk("R8 large addr", g_addr, 64'h8_0020_0000 | (va & 64'h1F_FFFF));
        chk("R8 large size", g_size, 64'h20_0000 - (va & 64'h1F_FFFF));
        chk("R8 walk stops", 64'(nreads), 64'd5);
        chk("R8 no fault", 64'(g_fault), 64'd0);
    endtask

    task automatic t_large_leaf;
        logic [63:0] va = 64'h0000_0000_2345_6DEF;
        mem.delete(); mem_lat = 3;
        set_ctx(16'h0203, PT_L0, 3'd0, 1'b1, 1'b1);
        put_pte(PT_L0, va, 1, PT_L1 | 64'h3);
        put_pte(PT_L1, va, 0, 64'h7000_0083);
        do_req(16'h0203, va, 1'b1);
        chk("R8 level0 bit ignored addr", g_addr, 64'h7000_0DEF);
        chk("R8 level0 bit ignored size", g_size, 64'h211);
        chk("R5 read count 2 levels", 64'(nreads), 64'd5);
    endtask

    task automatic t_empty_entry;
        logic [63:0] va = 64'h0000_0101_0202_0303;
        mem.delete(); mem_lat = 0;
        set_ctx(16'h0404, PT_L0, 3'd2, 1'b1, 1'b1);
        put_pte(PT_L0, va, 3, PT_L1 | 64'h3);
        put_pte(PT_L1, va, 2, PT_L2 | 64'h80);
        do_req(16'h0404, va, 1'b0);
        chk("R7 fault", 64'(g_fault), 64'd1);
        chk("R7 perm", 64'(g_perm), 64'd0);
        chk("R7 addr", g_addr, 64'd0);
        chk("R7 size", g_size, 64'd0);
        chk("R7 stops", 64'(nreads), 64'd5);
    endtask

    task automatic t_not_present;
        mem.delete(); mem_lat = 1;
        set_ctx(16'h0909, PT_L0, 3'd1, 1'b0, 1'b1);
        do_req(16'h0909, 64'h1000, 1'b0);
        chk("R4 root absent fault", 64'(g_fault), 64'd1);
        chk("R4 root absent perm", 64'(g_perm), 64'd0);
        chk("R4 root absent reads", 64'(nreads), 64'd1);
        mem.delete();
        set_ctx(16'h0909, PT_L0, 3'd1, 1'b1, 1'b0);
        do_req(16'h0909, 64'h1000, 1'b0);
        chk("R4 ctx absent fault", 64'(g_fault), 64'd1);
        chk("R4 ctx absent reads", 64'(nreads), 64'd2);
    endtask

    task automatic t_bad_code;
        mem.delete(); mem_lat = 0;
        set_ctx(16'h0A0B, PT_L0, 3'd4, 1'b1, 1'b1);
        do_req(16'h0A0B, 64'h2000, 1'b0);
        chk("R5 bad code fault", 64'(g_fault), 64'd1);
        chk("R5 bad code perm", 64'(g_perm), 64'd0);
        chk("R5 bad code no table reads", 64'(nreads), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass_through();
        t_no_root();
        t_full_walk();
        t_perm_mix();
        t_large_page();
        t_large_leaf();
        t_empty_entry();
        t_not_present();
        t_bad_code();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule